// File: doc/BRIEF.md
# Dual-Path Add/Subtract Unit

This unit executes one packed arithmetic instruction that produces two 32-bit results from a single pair of source registers. The two result paths share the operands. Each path adds or subtracts according to its own selector bit, writes to its own destination register, and records its own carry flag in a 32-bit control register. The unit contains a 16-entry by 32-bit register file in which entry 0 is hardwired to zero.

An instruction word arrives together with a valid strobe. In the same clock edge the unit decodes the fields, reads both sources from the state that existed before the edge, and commits the results and flags. The decoder classifies each cycle with one of four verdicts:
- `VERD_IDLE`: no valid strobe.
- `VERD_BADPAD`: the padding field is nonzero.
- `VERD_NODEST`: both destination indices are zero.
- `VERD_EXEC`: the instruction executes.

Only `VERD_EXEC` enables writes. The transitions between verdicts are combinational and are chosen again in every cycle. No verdict carries over to the next instruction.

The surrounding datapath fills the register file through a plain load port. A debug port reads any entry combinationally, and the control register is always visible on an output.

Top module: `dpas_unit`

## Requirements
- R1: The instruction word carries these fields:
  - pattern: bits 25:24
  - padding: bits 23:22
  - second destination: bits 21:18
  - second source: bits 17:14
  - first source: bits 13:10
  - first destination: bits 9:6
  All other bits are ignored.
- R2: Pattern bit 25 set makes the first-destination path subtract. Pattern bit 24 set makes the second-destination path subtract. A cleared bit selects addition.
- R3: A valid instruction with nonzero padding changes no register and no flag.
- R4: A valid instruction whose two destination indices are both zero changes no register and no flag.
- R5: A path writes either first source plus second source, or first source minus second source, modulo 2^32.
- R6: On an add path the flag is 1 exactly when the first source is unsigned-greater than the 32-bit sum.
- R7: On a subtract path the flag is 1 exactly when the first source is unsigned-strictly-greater than the second source. Equal operands give 0.
- R8: The first-destination path writes its flag to control bit 31, and the second-destination path writes its flag to control bit 30. Every other control bit keeps its value.
- R9: A path whose destination index is zero writes no register and leaves its flag bit unchanged.
- R10: Register index 0 always reads 0 and ignores writes. Entries 1 to 15 and the control register are cleared by reset.
- R11: When both destination indices are equal and nonzero, the second-destination path's result is the value stored.
- R12: Updates happen on the clock edge at which the valid strobe is sampled high, and operands come from the state before that edge. Without the strobe nothing changes.
- R13: When the load enable is high, the load port writes its data to the indexed entry on the clock edge. An instruction write to the same entry in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_valid | input | 1 | Instruction strobe |
| insn_word | input | 32 | Instruction word |
| load_en | input | 1 | Register-file load enable |
| load_idx | input | 4 | Load target index |
| load_data | input | 32 | Load data |
| dbg_idx | input | 4 | Debug read index |
| dbg_data | output | 32 | Debug read data |
| ctrl_flags | output | 32 | Control register value |

## Verification
The arithmetic is exercised with four operand patterns:
- a small sum with no carry
- a sum that wraps past 2^32
- equal operands under subtraction, which separates a strict comparison from a greater-or-equal comparison
- a smaller first source under subtraction, which wraps with a clear flag

All four pattern codes are applied, so that swapped selector bits or swapped flag positions show up. Several cases are aimed at specific faults:
- Cases with one destination zeroed and a flag preset to 1 reveal a skipped path that still touches its flag.
- Using the same destination for both paths reveals which path wins the write.
- An instruction that overwrites one of its own sources reveals operands taken from updated state.
- A word with bad padding, a word with both destinations zero, and a word presented without its strobe each show that no-ops are respected.

// File: rtl/dpas_pkg.sv
package dpas_pkg;
    // Field positions inside the instruction word (behavioural: decoded below)
    localparam int PAT_HI  = 25;
    localparam int PAT_LO  = 24;
    localparam int PAD_HI  = 23;
    localparam int PAD_LO  = 22;
    localparam int DST2_LO = 18;
    localparam int SRC2_LO = 14;
    localparam int SRC1_LO = 10;
    localparam int DST1_LO = 6;

    // Per-cycle decode verdict
    typedef enum logic [1:0] {
        VERD_IDLE,
        VERD_BADPAD,
        VERD_NODEST,
        VERD_EXEC
    } verdict_e;
endpackage

// File: rtl/dpas_decode.sv
module dpas_decode
    import dpas_pkg::*;
#(
    parameter int IW   = 32,
    parameter int IDXW = 4
) (
    input  logic            insn_valid,
    input  logic [IW-1:0]   insn,
    output logic [IDXW-1:0] src1_idx,
    output logic [IDXW-1:0] src2_idx,
    output logic [IDXW-1:0] dst1_idx,
    output logic [IDXW-1:0] dst2_idx,
    output logic            sub1,
    output logic            sub2,
    output logic            we1,
    output logic            we2
);
    verdict_e verdict;
    logic     unused_bits;

    assign unused_bits = ^{insn[IW-1:PAT_HI+1], insn[DST1_LO-1:0]};

    always_comb begin
        src1_idx = insn[SRC1_LO +: IDXW];
        src2_idx = insn[SRC2_LO +: IDXW];
        dst1_idx = insn[DST1_LO +: IDXW];
        dst2_idx = insn[DST2_LO +: IDXW];
        sub1     = insn[PAT_HI];
        sub2     = insn[PAT_LO];

        if (!insn_valid)
            verdict = VERD_IDLE;
        else if (insn[PAD_HI:PAD_LO] != '0)
            verdict = VERD_BADPAD;
        else if (dst1_idx == '0 && dst2_idx == '0)
            verdict = VERD_NODEST;
        else
            verdict = VERD_EXEC;

        we1 = 1'b0;
        we2 = 1'b0;
        unique case (verdict)
            VERD_EXEC: begin
                we1 = (dst1_idx != '0);
                we2 = (dst2_idx != '0);
            end
            VERD_IDLE, VERD_BADPAD, VERD_NODEST: begin
                we1 = 1'b0;
                we2 = 1'b0;
            end
            default: begin
                we1 = 1'b0;
                we2 = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/dpas_lane.sv
module dpas_lane #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         sub,
    output logic [W-1:0] res,
    output logic         carry
);
    always_comb begin
        if (sub) begin
            res   = opa - opb;
            carry = (opa > opb);
        end else begin
            res   = opa + opb;
            carry = (opa > res);
        end
    end
endmodule

// File: rtl/dpas_regfile.sv
module dpas_regfile #(
    parameter int W    = 32,
    parameter int IDXW = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ld_en,
    input  logic [IDXW-1:0] ld_idx,
    input  logic [W-1:0]    ld_data,
    input  logic            we1,
    input  logic [IDXW-1:0] wi1,
    input  logic [W-1:0]    wd1,
    input  logic            we2,
    input  logic [IDXW-1:0] wi2,
    input  logic [W-1:0]    wd2,
    input  logic [IDXW-1:0] ra1,
    output logic [W-1:0]    rd1,
    input  logic [IDXW-1:0] ra2,
    output logic [W-1:0]    rd2,
    input  logic [IDXW-1:0] dbg_idx,
    output logic [W-1:0]    dbg_data
);
    localparam int DEPTH = 2 ** IDXW;

    logic [W-1:0] mem [DEPTH];

    // Later assignments win: load < path 1 < path 2 < zero entry
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            if (ld_en) mem[ld_idx] <= ld_data;
            if (we1)   mem[wi1]    <= wd1;
            if (we2)   mem[wi2]    <= wd2;
            mem[0] <= '0;
        end
    end

    assign rd1      = mem[ra1];
    assign rd2      = mem[ra2];
    assign dbg_data = mem[dbg_idx];

    // R11: equal nonzero destinations keep the second path's value
    assert_same_dest_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (we1 && we2 && wi1 == wi2 && wi1 != '0) |=> (mem[$past(wi1)] == $past(wd2)));

    // R13: a lone load lands in its entry
    assert_load_lands_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_en && ld_idx != '0 && !we1 && !we2) |=> (mem[$past(ld_idx)] == $past(ld_data)));
endmodule

// File: rtl/dpas_unit.sv
module dpas_unit
    import dpas_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int IW        = 32,
    parameter int IDXW      = 4,
    parameter int FLAG1_BIT = 31,
    parameter int FLAG2_BIT = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    input  logic [IW-1:0]   insn_word,
    input  logic            load_en,
    input  logic [IDXW-1:0] load_idx,
    input  logic [XLEN-1:0] load_data,
    input  logic [IDXW-1:0] dbg_idx,
    output logic [XLEN-1:0] dbg_data,
    output logic [XLEN-1:0] ctrl_flags
);
    localparam int NPATH = 2;

    logic [IDXW-1:0] src1_idx, src2_idx, dst1_idx, dst2_idx;
    logic            sub1, sub2, we1, we2;
    logic [XLEN-1:0] rd1, rd2;
    logic            lane_sub [NPATH];
    logic [XLEN-1:0] lane_res [NPATH];
    logic            lane_cy  [NPATH];
    logic [XLEN-1:0] ctrl_q, ctrl_d;

    dpas_decode #(.IW(IW), .IDXW(IDXW)) u_dec (
        .insn_valid (insn_valid),
        .insn       (insn_word),
        .src1_idx   (src1_idx),
        .src2_idx   (src2_idx),
        .dst1_idx   (dst1_idx),
        .dst2_idx   (dst2_idx),
        .sub1       (sub1),
        .sub2       (sub2),
        .we1        (we1),
        .we2        (we2)
    );

    dpas_regfile #(.W(XLEN), .IDXW(IDXW)) u_rf (
        .clk      (clk),
        .rst_n    (rst_n),
        .ld_en    (load_en),
        .ld_idx   (load_idx),
        .ld_data  (load_data),
        .we1      (we1),
        .wi1      (dst1_idx),
        .wd1      (lane_res[0]),
        .we2      (we2),
        .wi2      (dst2_idx),
        .wd2      (lane_res[1]),
        .ra1      (src1_idx),
        .rd1      (rd1),
        .ra2      (src2_idx),
        .rd2      (rd2),
        .dbg_idx  (dbg_idx),
        .dbg_data (dbg_data)
    );

    assign lane_sub[0] = sub1;
    assign lane_sub[1] = sub2;

    for (genvar p = 0; p < NPATH; p++) begin : g_path
        dpas_lane #(.W(XLEN)) u_lane (
            .opa   (rd1),
            .opb   (rd2),
            .sub   (lane_sub[p]),
            .res   (lane_res[p]),
            .carry (lane_cy[p])
        );
    end

    always_comb begin
        ctrl_d = ctrl_q;
        if (we1) ctrl_d[FLAG1_BIT] = lane_cy[0];
        if (we2) ctrl_d[FLAG2_BIT] = lane_cy[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl_flags = ctrl_q;

    // R3: bad padding is a no-op for the flags
    assert_pad_noop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[PAD_HI:PAD_LO] != '0) |=> $stable(ctrl_flags));

    // R4: both destinations zero is a no-op for the flags
    assert_nodest_noop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[DST1_LO +: IDXW] == '0 && insn_word[DST2_LO +: IDXW] == '0)
        |=> $stable(ctrl_flags));

    // R9: a skipped first path keeps its flag
    assert_skip_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[DST1_LO +: IDXW] == '0)
        |=> (ctrl_flags[FLAG1_BIT] == $past(ctrl_flags[FLAG1_BIT])));

    // R9: a skipped second path keeps its flag
    assert_skip_second_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[DST2_LO +: IDXW] == '0)
        |=> (ctrl_flags[FLAG2_BIT] == $past(ctrl_flags[FLAG2_BIT])));

    // R7: equal operands under subtraction leave a clear flag
    assert_sub_equal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && insn_word[PAD_HI:PAD_LO] == '0 && insn_word[PAT_HI]
         && insn_word[DST1_LO +: IDXW] != '0 && rd1 == rd2)
        |=> !ctrl_flags[FLAG1_BIT]);

    // R12: no strobe, no flag change
    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> $stable(ctrl_flags));
endmodule

// File: tb/sim_dpas_unit.sv
`timescale 1ns/1ps
module sim_dpas_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn_word = '0;
    logic        load_en = 1'b0;
    logic [3:0]  load_idx = '0;
    logic [31:0] load_data = '0;
    logic [3:0]  dbg_idx = '0;
    logic [31:0] dbg_data;
    logic [31:0] ctrl_flags;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dpas_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .insn_valid (insn_valid),
        .insn_word  (insn_word),
        .load_en    (load_en),
        .load_idx   (load_idx),
        .load_data  (load_data),
        .dbg_idx    (dbg_idx),
        .dbg_data   (dbg_data),
        .ctrl_flags (ctrl_flags)
    );

    function automatic logic [31:0] mk(input logic [1:0] pat, input logic [1:0] pad,
                                       input logic [3:0] d2, input logic [3:0] s2,
                                       input logic [3:0] s1, input logic [3:0] d1);
        return {6'b0, pat, pad, d2, s2, s1, d1, 6'b0};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] idx, output logic [31:0] val);
        dbg_idx = idx;
        #0.5;
        val = dbg_data;
    endtask

    task automatic chk_reg(input string req, input logic [3:0] idx, input logic [31:0] exp);
        logic [31:0] v;
        rd(idx, v);
        chk(req, v, exp);
    endtask

    task automatic load(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        load_en = 1'b1; load_idx = idx; load_data = val;
        @(negedge clk);
        load_en = 1'b0;
    endtask

    task automatic run(input logic [31:0] w);
        @(negedge clk);
        insn_valid = 1'b1; insn_word = w;
        @(negedge clk);
        insn_valid = 1'b0;
    endtask

    task automatic t_reset;
        chk("R10 reset ctrl", ctrl_flags, 32'h0);
        for (int i = 0; i < 16; i++) chk_reg("R10 reset reg", 4'(i), 32'h0);
    endtask

    task automatic t_add_basic;
        load(4'd1, 32'd5); load(4'd2, 32'd3);
        chk_reg("R13 load r1", 4'd1, 32'd5);
        run(mk(2'b00, 2'b00, 4'd4, 4'd2, 4'd1, 4'd3));
        chk_reg("R5 add first", 4'd3, 32'd8);
        chk_reg("R1 add second", 4'd4, 32'd8);
        chk("R6 no carry", ctrl_flags, 32'h0);
    endtask

    task automatic t_sub_first;
        run(mk(2'b10, 2'b00, 4'd6, 4'd2, 4'd1, 4'd5));
        chk_reg("R2 first path subtracts", 4'd5, 32'd2);
        chk_reg("R2 second path adds", 4'd6, 32'd8);
        chk("R7 R8 flag bit31", ctrl_flags, 32'h8000_0000);
    endtask

    task automatic t_sub_second;
        run(mk(2'b01, 2'b00, 4'd8, 4'd2, 4'd1, 4'd7));
        chk_reg("R2 first path adds", 4'd7, 32'd8);
        chk_reg("R2 second path subtracts", 4'd8, 32'd2);
        chk("R8 flag bit30", ctrl_flags, 32'h4000_0000);
    endtask

    task automatic t_add_overflow;
        load(4'd1, 32'hFFFF_FFFF); load(4'd2, 32'd2);
        run(mk(2'b00, 2'b00, 4'd10, 4'd2, 4'd1, 4'd9));
        chk_reg("R5 wrap", 4'd9, 32'd1);
        chk_reg("R5 wrap second", 4'd10, 32'd1);
        chk("R6 carry both", ctrl_flags, 32'hC000_0000);
    endtask

    task automatic t_sub_equal_borrow;
        load(4'd11, 32'd7); load(4'd12, 32'd7);
        run(mk(2'b11, 2'b00, 4'd14, 4'd12, 4'd11, 4'd13));
        chk_reg("R5 equal diff", 4'd13, 32'd0);
        chk("R7 equal gives 0", ctrl_flags, 32'h0);
        load(4'd11, 32'd3); load(4'd12, 32'd5);
        run(mk(2'b11, 2'b00, 4'd14, 4'd12, 4'd11, 4'd13));
        chk_reg("R5 borrow wrap", 4'd14, 32'hFFFF_FFFE);
        chk("R7 smaller first gives 0", ctrl_flags, 32'h0);
    endtask

    task automatic t_skip_path;
        run(mk(2'b00, 2'b00, 4'd10, 4'd2, 4'd1, 4'd9));
        chk("R8 preset flags", ctrl_flags, 32'hC000_0000);
        run(mk(2'b01, 2'b00, 4'd15, 4'd12, 4'd11, 4'd0));
        chk_reg("R9 second path only", 4'd15, 32'hFFFF_FFFE);
        chk("R9 bit31 kept", ctrl_flags, 32'h8000_0000);
        run(mk(2'b00, 2'b00, 4'd10, 4'd2, 4'd1, 4'd9));
        run(mk(2'b10, 2'b00, 4'd0, 4'd12, 4'd11, 4'd9));
        chk_reg("R9 first path only", 4'd9, 32'hFFFF_FFFE);
        chk_reg("R9 skipped reg untouched", 4'd10, 32'd1);
        chk("R9 bit30 kept", ctrl_flags, 32'h4000_0000);
    endtask

    task automatic t_bad_pad;
        run(mk(2'b11, 2'b01, 4'd3, 4'd2, 4'd1, 4'd3));
        run(mk(2'b00, 2'b10, 4'd4, 4'd2, 4'd1, 4'd4));
        chk_reg("R3 r3 kept", 4'd3, 32'd8);
        chk_reg("R3 r4 kept", 4'd4, 32'd8);
        chk("R3 flags kept", ctrl_flags, 32'h4000_0000);
    endtask

    task automatic t_no_dest;
        run(mk(2'b00, 2'b00, 4'd0, 4'd2, 4'd1, 4'd0));
        chk("R4 flags kept", ctrl_flags, 32'h4000_0000);
        chk_reg("R4 r0 zero", 4'd0, 32'd0);
    endtask

    task automatic t_same_dest;
        run(mk(2'b10, 2'b00, 4'd5, 4'd2, 4'd1, 4'd5));
        chk_reg("R11 second path wins", 4'd5, 32'd1);
        chk("R11 both flags", ctrl_flags, 32'hC000_0000);
    endtask

    task automatic t_old_operands;
        load(4'd1, 32'd10); load(4'd2, 32'd20);
        run(mk(2'b00, 2'b00, 4'd2, 4'd2, 4'd1, 4'd1));
        chk_reg("R12 r1 from old", 4'd1, 32'd30);
        chk_reg("R12 r2 from old", 4'd2, 32'd30);
        chk("R12 flags", ctrl_flags, 32'h0);
    endtask

    task automatic t_no_valid;
        @(negedge clk);
        insn_word = mk(2'b11, 2'b00, 4'd3, 4'd2, 4'd1, 4'd3);
        @(negedge clk);
        @(negedge clk);
        insn_word = '0;
        chk_reg("R12 no strobe r3", 4'd3, 32'd8);
        chk("R12 no strobe flags", ctrl_flags, 32'h0);
    endtask

    task automatic t_zero_reg;
        load(4'd0, 32'hDEAD_BEEF);
        chk_reg("R10 r0 ignores load", 4'd0, 32'd0);
        load(4'd1, 32'd4); load(4'd2, 32'd4);
        run(mk(2'b00, 2'b00, 4'd0, 4'd2, 4'd1, 4'd6));
        chk_reg("R10 r0 after insn", 4'd0, 32'd0);
        chk_reg("R13 r6 written", 4'd6, 32'd8);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add_basic();
        t_sub_first();
        t_sub_second();
        t_add_overflow();
        t_sub_equal_borrow();
        t_skip_path();
        t_bad_pad();
        t_no_dest();
        t_same_dest();
        t_old_operands();
        t_no_valid();
        t_zero_reg();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule